// File: doc/BRIEF.md
# MDIO Command Engine

This block lets software run single management-bus transactions toward an Ethernet PHY through a few registers. Software first loads a data word, then writes a command word that carries a start flag, a read or write opcode, a 5-bit PHY address and a 5-bit register address. The engine then clocks out one complete clause-22 frame on MDC/MDIO. The frame has a preamble of ones, the start pattern, the opcode, both addresses, a turnaround and sixteen data bits. Completion is signalled by the start flag reading back as zero.

A write frame takes its payload from the low half of the data register. A read frame releases the data line at the turnaround and shifts sixteen bits in from the PHY. These bits land in the high half of the data register. A status flag records whether the PHY answered the read. MDC runs only during a frame. It is produced by dividing the system clock by a parameter. MDIO is updated when MDC falls and sampled when MDC rises.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command, data and status words read 0, MDC is low and the MDIO output enable is low.
- R2: A command write is accepted only when the engine is idle, bit 20 is 1 and exactly one of bits 17 (read) and 16 (write) is 1. After acceptance the command word reads back the value written with bit 20 at 1. Bit 20 stays 1 for exactly 128*HALF_DIV clock cycles and then clears, while every other bit keeps the written value.
- R3: A write frame is 32 ones, then 01, opcode 01, PHY address from command bits 12:8, register address from command bits 4:0, turnaround 10, and data register bits 15:0. Every field is sent MSB first, and the output enable is high for all 64 bits.
- R4: A read frame sends the same first 46 bits with opcode 10. The output enable is low from the first turnaround bit through the last data bit.
- R5: At the end of a read, the 16 bits sampled after the turnaround (first sampled bit in bit 31) are placed in data register bits 31:16. Bits 15:0 are left unchanged.
- R6: Status bit 0 is set at the end of a read when the second turnaround bit was sampled high, and cleared when it was sampled low. A write frame leaves the flag unchanged.
- R7: While a frame is in progress, writes to the command word (select 0) and to the data word (select 1) are ignored. The running frame is unaffected, and no second frame follows it.
- R8: MDC spends exactly HALF_DIV clock cycles in each phase during a frame. MDIO changes only when MDC falls.
- R9: A command write with bit 20 clear, or with bits 17 and 16 both set or both clear, starts no frame and leaves the command word unchanged.
- R10: When idle, MDC stays low and the output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 data, others ignored |
| wr_data | input | 32 | Register write value |
| cmd_word | output | 32 | Command word readback, bit 20 = busy |
| data_word | output | 32 | Data word: write payload low, read result high |
| stat_word | output | 32 | Status word, bit 0 = read got no valid answer |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Directed frames come first, with fixed addresses and payloads. These are a write, a responsive read and an unresponsive read. They check the bit order of each field and the read turnaround. Seeded random transactions follow. They vary the opcode, the addresses, the payload, the reserved command bits and whether the PHY answers. This shows that the field extraction ignores neighbouring bits and that the status flag follows only reads. Writes issued mid-frame and malformed commands check that nothing disturbs a running frame and that nothing starts without a valid command. Half-period measurement of MDC separates a correct divider from one that is off by a cycle.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
    localparam int FRAME_LEN  = 64;
    localparam int TA_FIRST   = 46;
    localparam int TA_LAST    = 47;
    localparam int DATA_FIRST = 48;
    localparam int CNT_W      = $clog2(FRAME_LEN);
    localparam int START_BIT  = 20;
    localparam int RD_BIT     = 17;
    localparam int WR_BIT     = 16;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1
    } reg_sel_e;

    typedef struct packed {
        logic                 busy;
        logic                 is_read;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_LEN-1:0] tx;
        logic [15:0]          rx;
        logic                 bad;
    } shf_state_t;

    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] data;
        logic        bad;
    } reg_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d  = div_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!en_i) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (div_q.cnt == CW'(HALF_DIV - 1)) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
            rise_o    = ~div_q.mdc;
            fall_o    = div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc_o = div_q.mdc;

    // R10: with the engine idle the clock is parked low
    assert_mdc_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_eng_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  reg_i,
    input  logic [15:0] wdata_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        fin_o,
    output logic [15:0] rdata_o,
    output logic        bad_o,
    output logic        mdio_o,
    output logic        mdio_oe
);
    shf_state_t sh_d, sh_q;
    logic last_bit;

    assign last_bit = (sh_q.cnt == CNT_W'(FRAME_LEN - 1));

    always_comb begin
        sh_d = sh_q;
        if (!sh_q.busy) begin
            if (start_i) begin
                sh_d.busy    = 1'b1;
                sh_d.is_read = rd_i;
                sh_d.cnt     = '0;
                sh_d.rx      = '0;
                sh_d.bad     = 1'b0;
                sh_d.tx      = {32'hFFFF_FFFF, 2'b01,
                                (rd_i ? 2'b10 : 2'b01),
                                phy_i, reg_i,
                                (rd_i ? 2'b11 : 2'b10),
                                (rd_i ? 16'hFFFF : wdata_i)};
            end
        end else begin
            if (rise_i && sh_q.is_read) begin
                if (sh_q.cnt == CNT_W'(TA_LAST))
                    sh_d.bad = mdio_i;
                if (sh_q.cnt >= CNT_W'(DATA_FIRST))
                    sh_d.rx = {sh_q.rx[14:0], mdio_i};
            end
            if (fall_i) begin
                if (last_bit) begin
                    sh_d.busy = 1'b0;
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                    sh_d.tx  = {sh_q.tx[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sh_q.tx <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy_o  = sh_q.busy;
    assign fin_o   = sh_q.busy && fall_i && last_bit;
    assign rdata_o = sh_q.rx;
    assign bad_o   = sh_q.bad;
    assign mdio_o  = sh_q.tx[FRAME_LEN-1];
    assign mdio_oe = sh_q.busy && !(sh_q.is_read && sh_q.cnt >= CNT_W'(TA_FIRST));

    // R2: a running frame only ends at the final falling MDC edge
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fin_o) |=> busy_o);

    // R8: MDIO moves only on a falling MDC edge within a frame
    assert_mdio_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(fall_i)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_eng_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] cmd_word,
    output logic [31:0] data_word,
    output logic [31:0] stat_word,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    reg_state_t rg_d, rg_q;
    logic busy, fin, start, rise, fall, rx_bad;
    logic [15:0] rx_data;
    logic cmd_ok;

    assign cmd_ok = wr_data[START_BIT] && (wr_data[RD_BIT] ^ wr_data[WR_BIT]);
    assign start  = wr_en && !busy && (wr_sel == SEL_CMD) && cmd_ok;

    always_comb begin
        rg_d = rg_q;
        if (start)
            rg_d.cmd = wr_data;
        if (wr_en && !busy && wr_sel == SEL_DATA)
            rg_d.data = wr_data;
        if (fin && rg_q.cmd[RD_BIT]) begin
            rg_d.data[31:16] = rx_data;
            rg_d.bad         = rx_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .rd_i    (wr_data[RD_BIT]),
        .phy_i   (wr_data[12:8]),
        .reg_i   (wr_data[4:0]),
        .wdata_i (rg_q.data[15:0]),
        .rise_i  (rise),
        .fall_i  (fall),
        .mdio_i  (mdio_i),
        .busy_o  (busy),
        .fin_o   (fin),
        .rdata_o (rx_data),
        .bad_o   (rx_bad),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    assign cmd_word  = {rg_q.cmd[31:START_BIT+1], busy, rg_q.cmd[START_BIT-1:0]};
    assign data_word = rg_q.data;
    assign stat_word = {31'd0, rg_q.bad};

    // R7: command fields are frozen while a frame runs
    assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(rg_q.cmd));

    // R7: the write payload cannot change under a running frame
    assert_data_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(rg_q.data));

    // R6: a finished write frame leaves the status flag alone
    assert_status_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !rg_q.cmd[RD_BIT]) |=> $stable(rg_q.bad));
endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
    localparam int HALF = 4;
    localparam int FRAME_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_word, data_word, stat_word;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mdio_cmd_engine #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cmd_word(cmd_word), .data_word(data_word),
        .stat_word(stat_word), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model and frame capture
    int          cap_idx = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    logic        phy_answers = 1'b1;
    logic [15:0] phy_data = '0;

    always @(posedge mdc) begin
        if (cap_idx < 64) begin
            cap_bits[63-cap_idx] = mdio_o;
            cap_oe[63-cap_idx]   = mdio_oe;
            cap_idx++;
        end
    end

    always @(negedge mdc) begin
        if (cap_idx == 47)
            mdio_i = phy_answers ? 1'b0 : 1'b1;
        else if (cap_idx >= 48 && cap_idx < 64)
            mdio_i = phy_answers ? phy_data[63-cap_idx] : 1'b1;
        else
            mdio_i = 1'b1;
    end

    // MDC half-period monitor
    int   half_cnt = 0;
    int   mdc_err = 0;
    logic mdc_prev = 1'b0;
    logic seen_edge = 1'b0;
    always @(negedge clk) begin
        half_cnt++;
        if (mdc !== mdc_prev) begin
            if (seen_edge && half_cnt != HALF) mdc_err++;
            seen_edge = 1'b1;
            half_cnt  = 0;
        end
        mdc_prev = mdc;
        if (!cmd_word[20]) seen_edge = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (cmd_word[20] && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
    endfunction

    function automatic logic [63:0] exp_oe(input bit rd);
        return rd ? ({64{1'b1}} << 18) : {64{1'b1}};
    endfunction

    function automatic logic [31:0] make_cmd(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [31:0] junk);
        logic [31:0] c;
        c = junk & 32'hFFEC_E0E0;
        c[20] = 1'b1;
        c[17] = rd;
        c[16] = !rd;
        c[12:8] = p;
        c[4:0] = r;
        return c;
    endfunction

    logic exp_bad = 1'b0;

    task automatic run_txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [31:0] dval, input bit ans,
                           input logic [15:0] rsp, input logic [31:0] junk);
        logic [31:0] c;
        logic [63:0] f;
        int cyc;
        reg_write(2'd1, dval);
        cap_idx = 0; mdc_err = 0;
        phy_answers = ans; phy_data = rsp; mdio_i = 1'b1;
        c = make_cmd(rd, p, r, junk);
        reg_write(2'd0, c);
        chk(cmd_word == c, "R2 accepted command readback", {32'd0, cmd_word}, {32'd0, c});
        wait_idle(cyc);
        chk(cyc == FRAME_CYC, "R2 busy duration", 64'(cyc), 64'(FRAME_CYC));
        chk(cmd_word == (c & ~32'h0010_0000), "R2 busy cleared, fields kept",
            {32'd0, cmd_word}, {32'd0, c & ~32'h0010_0000});
        f = exp_frame(rd, p, r, dval[15:0]);
        if (rd) begin
            chk(cap_bits[63:18] == f[63:18], "R4 read frame header", cap_bits, f);
            chk(cap_oe == exp_oe(1'b1), "R4 read turnaround release", cap_oe, exp_oe(1'b1));
            chk(data_word == {(ans ? rsp : 16'hFFFF), dval[15:0]}, "R5 read data placement",
                {32'd0, data_word}, {32'd0, (ans ? rsp : 16'hFFFF), dval[15:0]});
            exp_bad = !ans;
        end else begin
            chk(cap_bits == f, "R3 write frame bits", cap_bits, f);
            chk(cap_oe == exp_oe(1'b0), "R3 write drive enable", cap_oe, exp_oe(1'b0));
        end
        chk(stat_word == {31'd0, exp_bad}, "R6 status flag", {32'd0, stat_word},
            {63'd0, exp_bad});
        chk(mdc_err == 0, "R8 MDC half period", 64'(mdc_err), 64'd0);
        chk(!mdc && !mdio_oe, "R10 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] c0, prev;
        logic [63:0] f0;
        int cyc;
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(cmd_word == 0 && data_word == 0 && stat_word == 0, "R1 reset registers",
            {32'd0, cmd_word | data_word | stat_word}, 64'd0);
        chk(!mdc && !mdio_oe, "R1 reset pins", {62'd0, mdc, mdio_oe}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mdc && !mdio_oe, "R10 idle after reset", {62'd0, mdc, mdio_oe}, 64'd0);

        // directed write, read, failed read, write preserving flag, good read
        run_txn(1'b0, 5'h15, 5'h0A, 32'h1234_ABCD, 1'b1, 16'h0, 32'h0);
        run_txn(1'b1, 5'h03, 5'h02, 32'h0000_5A5A, 1'b1, 16'hBEEF, 32'h0);
        run_txn(1'b1, 5'h1F, 5'h1F, 32'h7777_0001, 1'b0, 16'h0, 32'hFFFF_FFFF);
        run_txn(1'b0, 5'h00, 5'h00, 32'h0000_8001, 1'b1, 16'h0, 32'h0);
        run_txn(1'b1, 5'h11, 5'h10, 32'h0000_C3C3, 1'b1, 16'h8001, 32'h0);

        // R7: writes during a running frame are ignored
        reg_write(2'd1, 32'h0000_A5A5);
        cap_idx = 0;
        c0 = make_cmd(1'b0, 5'h0C, 5'h13, 32'h0);
        reg_write(2'd0, c0);
        repeat (100) @(negedge clk);
        reg_write(2'd0, make_cmd(1'b1, 5'h01, 5'h01, 32'h0));
        reg_write(2'd1, 32'hFFFF_0000);
        chk(cmd_word == c0, "R7 command write ignored while busy", {32'd0, cmd_word}, {32'd0, c0});
        chk(data_word == 32'h0000_A5A5, "R7 data write ignored while busy",
            {32'd0, data_word}, 64'h0000_A5A5);
        wait_idle(cyc);
        f0 = exp_frame(1'b0, 5'h0C, 5'h13, 16'hA5A5);
        chk(cap_bits == f0, "R7 running frame undisturbed", cap_bits, f0);
        repeat (40) @(negedge clk);
        chk(cap_idx == 64 && !cmd_word[20], "R7 no second frame", 64'(cap_idx), 64'd64);

        // R9: malformed commands start nothing
        prev = cmd_word;
        cap_idx = 0;
        reg_write(2'd0, 32'h0013_0101);
        repeat (20) @(negedge clk);
        chk(cmd_word == prev && cap_idx == 0, "R9 both opcode bits", {32'd0, cmd_word}, {32'd0, prev});
        reg_write(2'd0, 32'h0010_0101);
        repeat (20) @(negedge clk);
        chk(cmd_word == prev && cap_idx == 0, "R9 no opcode bit", {32'd0, cmd_word}, {32'd0, prev});
        reg_write(2'd0, 32'h0002_0101);
        repeat (20) @(negedge clk);
        chk(cmd_word == prev && cap_idx == 0, "R9 start bit clear", {32'd0, cmd_word}, {32'd0, prev});

        // random transactions
        for (int i = 0; i < 12; i++) begin
            bit          rd;
            bit          ans;
            logic [4:0]  p, r;
            logic [31:0] dv, jk;
            logic [15:0] rs;
            rd  = $urandom_range(0, 1);
            ans = ($urandom_range(0, 3) != 0);
            p   = 5'($urandom);
            r   = 5'($urandom);
            dv  = $urandom;
            jk  = $urandom;
            rs  = 16'($urandom);
            run_txn(rd, p, r, dv, ans, rs, jk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule